// File: doc/BRIEF.md
# UART FIFO Level and Trigger Register Bank

This block owns the register-access logic behind the scratchpad address of a UART with 16-entry FIFOs. A feature-control byte decides what that address means. While its swap bit is clear, the address is a plain read/write byte. While the swap bit is set, a read returns the occupancy of one FIFO and a write lands in an enhanced-mode byte. The direction bit of the same feature-control byte steers both the count read and the programmable trigger write to either the receive side or the transmit side.

The feature-control byte has its own address and answers only while the line-control value equals 0xBF. The trigger byte is write-only. It answers at its address while the line-control value equals 0xBF or while the swap bit is set. A trigger-table selector picks either the two programmed levels or a fixed set of levels, and the result is driven out as the effective receive and transmit trigger levels. Read data is captured in a register on the read strobe, so it stays stable for the rest of the bus cycle.

Top module: `uartLevelRegs`

## Requirements
- R1: After reset (active-low `rstN`), `rdData`, `enhMode`, `irInvert` and `autoDirEn` are zero, and with `trigTableSel`=3 both trigger outputs are zero.
- R2: The feature-control byte sits at address 1 and is read and written only while `lcrValue`=0xBF. Bits 1:0 and 5:4 always read 0. Bit 2 drives `irInvert` and bit 3 drives `autoDirEn`. A write at address 1 under any other `lcrValue` changes nothing.
- R3: With feature bit 6 = 0, address 7 is a read/write scratchpad byte.
- R4: With feature bit 6 = 1, a read of address 7 returns `rxCount` when feature bit 7 = 0 and `txCount` when it is 1. Values above 16 read as 16.
- R5: With feature bit 6 = 1, a write to address 7 loads `enhMode` and leaves the scratchpad value unchanged.
- R6: A write to address 0 while `lcrValue`=0xBF or feature bit 6 = 1 loads the receive trigger when feature bit 7 = 0 and the transmit trigger when it is 1. A write to address 0 under any other condition is ignored. A read of address 0 returns 0.
- R7: With `trigTableSel`=3, `rxTrigLevel`/`txTrigLevel` show the programmed bytes. Otherwise both show the fixed level chosen by `fixedLevelSel`: 0→1, 1→4, 2→8, 3→14.
- R8: `rdData` changes only on the clock edge where `rdEn` is high, and then takes the value at that edge. It holds while `rdEn` is low. A write in the same cycle as a read is not seen by that read.
- R9: A read of any address this block does not own (2 to 6, or address 1 while locked) returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register address |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Registered read data |
| rxCount | input | 5 | Receive FIFO occupancy |
| txCount | input | 5 | Transmit FIFO occupancy |
| lcrValue | input | 8 | Current line-control register value |
| trigTableSel | input | 2 | Trigger table choice, 3 = programmable |
| fixedLevelSel | input | 2 | Index into the fixed level set |
| rxTrigLevel | output | 8 | Effective receive trigger level |
| txTrigLevel | output | 8 | Effective transmit trigger level |
| enhMode | output | 8 | Enhanced-mode byte |
| irInvert | output | 1 | Feature bit 2 |
| autoDirEn | output | 1 | Feature bit 3 |

## Verification
A wrong swap or direction bit shows up at the next read of address 7: the read returns the scratchpad instead of a count, or the wrong FIFO's count. It also shows up at once on the trigger outputs after the next write to address 0, because the byte lands in the wrong direction. A corrupted scratchpad, enhanced-mode or trigger byte is visible on the outputs the cycle after the write, or on the first read that follows. A read register that fails to hold is caught by changing the counts between reads.

// File: rtl/uartLevelPkg.sv
package uartLevelPkg;

  localparam logic [7:0] LCR_UNLOCK_CODE = 8'hBF;
  localparam logic [7:0] FEAT_WRITABLE   = 8'hCC;

  typedef struct packed {
    logic wrScratch;
    logic wrEnh;
    logic wrFeat;
    logic wrTrigRx;
    logic wrTrigTx;
    logic rdScratch;
    logic rdCount;
    logic rdFeat;
    logic rdAny;
    logic countTx;
  } regStrobeT;

endpackage

// File: rtl/uartLevelCtrl.sv
module uartLevelCtrl
  import uartLevelPkg::*;
#(
  parameter int ADDR_W       = 3,
  parameter int SCRATCH_ADDR = 7,
  parameter int FEAT_ADDR    = 1,
  parameter int TRIG_ADDR    = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [7:0]        lcrValue,
  input  logic              featSwap,
  input  logic              featDirTx,
  output regStrobeT         strobe
);

  localparam logic [ADDR_W-1:0] SCR_A  = ADDR_W'(SCRATCH_ADDR);
  localparam logic [ADDR_W-1:0] FEAT_A = ADDR_W'(FEAT_ADDR);
  localparam logic [ADDR_W-1:0] TRIG_A = ADDR_W'(TRIG_ADDR);

  logic unlocked;
  logic hitScratch;
  logic hitFeat;
  logic hitTrig;

  always_comb begin
    unlocked   = (lcrValue == LCR_UNLOCK_CODE);
    hitScratch = (addr == SCR_A);
    hitFeat    = (addr == FEAT_A) && unlocked;
    hitTrig    = (addr == TRIG_A) && (unlocked || featSwap);
  end

  always_comb begin
    strobe           = '0;
    strobe.wrScratch = wrEn && hitScratch && !featSwap;
    strobe.wrEnh     = wrEn && hitScratch && featSwap;
    strobe.wrFeat    = wrEn && hitFeat;
    strobe.wrTrigRx  = wrEn && hitTrig && !featDirTx;
    strobe.wrTrigTx  = wrEn && hitTrig && featDirTx;
    strobe.rdScratch = rdEn && hitScratch && !featSwap;
    strobe.rdCount   = rdEn && hitScratch && featSwap;
    strobe.rdFeat    = rdEn && hitFeat;
    strobe.rdAny     = rdEn;
    strobe.countTx   = featDirTx;
  end

  AST_ONE_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrScratch, strobe.wrEnh, strobe.wrFeat, strobe.wrTrigRx, strobe.wrTrigTx})); // R6

  AST_ONE_READ_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.rdScratch, strobe.rdCount, strobe.rdFeat})); // R9

endmodule

// File: rtl/uartLevelData.sv
module uartLevelData
  import uartLevelPkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  regStrobeT        strobe,
  input  logic [7:0]       wrData,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [CNT_W-1:0] txCount,
  output logic [7:0]       rdData,
  output logic [7:0]       progRx,
  output logic [7:0]       progTx,
  output logic [7:0]       enhMode,
  output logic             featSwap,
  output logic             featDirTx,
  output logic             irInvert,
  output logic             autoDirEn
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FIFO_DEPTH);

  logic [7:0]       featReg;
  logic [7:0]       scratchReg;
  logic [CNT_W-1:0] countPick;
  logic [7:0]       countSat;
  logic [7:0]       readMux;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      featReg    <= '0;
      scratchReg <= '0;
      enhMode    <= '0;
      progRx     <= '0;
      progTx     <= '0;
    end else begin
      if (strobe.wrFeat)    featReg    <= wrData & FEAT_WRITABLE;
      if (strobe.wrScratch) scratchReg <= wrData;
      if (strobe.wrEnh)     enhMode    <= wrData;
      if (strobe.wrTrigRx)  progRx     <= wrData;
      if (strobe.wrTrigTx)  progTx     <= wrData;
    end
  end

  always_comb begin
    countPick = strobe.countTx ? txCount : rxCount;
    countSat  = 8'((countPick > CNT_MAX) ? CNT_MAX : countPick);
    readMux   = '0;
    if (strobe.rdScratch) readMux = scratchReg;
    if (strobe.rdCount)   readMux = countSat;
    if (strobe.rdFeat)    readMux = featReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rdData <= '0;
    else if (strobe.rdAny) rdData <= readMux;
  end

  always_comb begin
    featSwap  = featReg[6];
    featDirTx = featReg[7];
    irInvert  = featReg[2];
    autoDirEn = featReg[3];
  end

  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdAny |=> $stable(rdData)); // R8

  AST_COUNT_CEILING: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdCount |=> (rdData <= 8'(FIFO_DEPTH))); // R4

  AST_ENH_WRITE_ONLY_WHEN_SWAPPED: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrEnh |=> $stable(enhMode)); // R5

  AST_SCRATCH_KEPT_WHEN_SWAPPED: assert property (@(posedge clk) disable iff (!rstN)
    featSwap |=> $stable(scratchReg)); // R5

endmodule

// File: rtl/uartTrigSelect.sv
module uartTrigSelect #(
  parameter int FIFO_DEPTH = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] progLevel,
  input  logic [1:0] tableSel,
  input  logic [1:0] fixedSel,
  output logic [7:0] level
);

  localparam logic [7:0] LVL_A = 8'd1;
  localparam logic [7:0] LVL_B = 8'(FIFO_DEPTH / 4);
  localparam logic [7:0] LVL_C = 8'(FIFO_DEPTH / 2);
  localparam logic [7:0] LVL_D = 8'(FIFO_DEPTH - 2);

  logic [7:0] fixedLevel;

  always_comb begin
    case (fixedSel)
      2'd0:    fixedLevel = LVL_A;
      2'd1:    fixedLevel = LVL_B;
      2'd2:    fixedLevel = LVL_C;
      default: fixedLevel = LVL_D;
    endcase
    level = (tableSel == 2'd3) ? progLevel : fixedLevel;
  end

  AST_FIXED_LEVEL_SET: assert property (@(posedge clk) disable iff (!rstN)
    (tableSel != 2'd3) |-> (level == LVL_A || level == LVL_B ||
                            level == LVL_C || level == LVL_D)); // R7

endmodule

// File: rtl/uartLevelRegs.sv
module uartLevelRegs
  import uartLevelPkg::*;
#(
  parameter int ADDR_W       = 3,
  parameter int FIFO_DEPTH   = 16,
  parameter int SCRATCH_ADDR = 7,
  parameter int FEAT_ADDR    = 1,
  parameter int TRIG_ADDR    = 0,
  localparam int CNT_W       = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  input  logic [CNT_W-1:0]  rxCount,
  input  logic [CNT_W-1:0]  txCount,
  input  logic [7:0]        lcrValue,
  input  logic [1:0]        trigTableSel,
  input  logic [1:0]        fixedLevelSel,
  output logic [7:0]        rxTrigLevel,
  output logic [7:0]        txTrigLevel,
  output logic [7:0]        enhMode,
  output logic              irInvert,
  output logic              autoDirEn
);

  regStrobeT  strobe;
  logic       featSwap;
  logic       featDirTx;
  logic [7:0] progLevel [2];
  logic [7:0] effLevel  [2];

  uartLevelCtrl #(
    .ADDR_W(ADDR_W), .SCRATCH_ADDR(SCRATCH_ADDR),
    .FEAT_ADDR(FEAT_ADDR), .TRIG_ADDR(TRIG_ADDR)
  ) ctrlInst (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .lcrValue(lcrValue), .featSwap(featSwap), .featDirTx(featDirTx),
    .strobe(strobe)
  );

  uartLevelData #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) dataInst (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .rxCount(rxCount), .txCount(txCount), .rdData(rdData),
    .progRx(progLevel[0]), .progTx(progLevel[1]), .enhMode(enhMode),
    .featSwap(featSwap), .featDirTx(featDirTx),
    .irInvert(irInvert), .autoDirEn(autoDirEn)
  );

  for (genvar dir = 0; dir < 2; dir++) begin : gTrig
    uartTrigSelect #(.FIFO_DEPTH(FIFO_DEPTH)) selInst (
      .clk(clk), .rstN(rstN), .progLevel(progLevel[dir]),
      .tableSel(trigTableSel), .fixedSel(fixedLevelSel),
      .level(effLevel[dir])
    );
  end

  assign rxTrigLevel = effLevel[0];
  assign txTrigLevel = effLevel[1];

endmodule

// File: tb/uartLevelRegs_test.sv
`timescale 1ns/1ps
module uartLevelRegs_test;

  logic       clk = 0;
  logic       rstN = 0;
  logic [2:0] addr = 0;
  logic       wrEn = 0, rdEn = 0;
  logic [7:0] wrData = 0, lcrValue = 0;
  logic [4:0] rxCount = 0, txCount = 0;
  logic [1:0] trigTableSel = 2'd3, fixedLevelSel = 0;
  logic [7:0] rdData, rxTrigLevel, txTrigLevel, enhMode;
  logic       irInvert, autoDirEn;

  int checks = 0, errors = 0;
  logic [7:0] featM = 0, scrM = 0, enhM = 0, trigRxM = 0, trigTxM = 0, rdM = 0;

  uartLevelRegs uut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .rxCount(rxCount), .txCount(txCount),
    .lcrValue(lcrValue), .trigTableSel(trigTableSel), .fixedLevelSel(fixedLevelSel),
    .rxTrigLevel(rxTrigLevel), .txTrigLevel(txTrigLevel), .enhMode(enhMode),
    .irInvert(irInvert), .autoDirEn(autoDirEn)
  );

  always #5 clk = ~clk;

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] sat16(logic [4:0] c);
    return (c > 5'd16) ? 8'd16 : {3'b0, c};
  endfunction

  function automatic logic [7:0] fixedLvl(logic [1:0] s);
    case (s)
      2'd0: return 8'd1;
      2'd1: return 8'd4;
      2'd2: return 8'd8;
      default: return 8'd14;
    endcase
  endfunction

  function automatic logic [7:0] expRead(logic [2:0] a, logic [7:0] lcr,
                                         logic [4:0] rxc, logic [4:0] txc);
    if (a == 3'd7) return featM[6] ? sat16(featM[7] ? txc : rxc) : scrM;
    if (a == 3'd1 && lcr == 8'hBF) return featM;
    return 8'h00;
  endfunction

  task automatic applyWrite(logic [2:0] a, logic [7:0] lcr, logic [7:0] d);
    logic unl = (lcr == 8'hBF);
    if (a == 3'd7) begin
      if (featM[6]) enhM = d; else scrM = d;
    end else if (a == 3'd1 && unl) featM = d & 8'hCC;
    else if (a == 3'd0 && (unl || featM[6])) begin
      if (featM[7]) trigTxM = d; else trigRxM = d;
    end
  endtask

  task automatic checkOutputs(string req);
    check(req, enhMode, enhM);
    check(req, {6'b0, autoDirEn, irInvert}, {6'b0, featM[3], featM[2]});
    check(req, rxTrigLevel, (trigTableSel == 2'd3) ? trigRxM : fixedLvl(fixedLevelSel));
    check(req, txTrigLevel, (trigTableSel == 2'd3) ? trigTxM : fixedLvl(fixedLevelSel));
  endtask

  // one bus cycle: drive at negedge, let the posedge act, sample at the next negedge
  task automatic busOp(bit doWr, bit doRd, logic [2:0] a, logic [7:0] d,
                       logic [7:0] lcr, string req);
    logic [7:0] e;
    @(negedge clk);
    addr = a; wrEn = doWr; rdEn = doRd; wrData = d; lcrValue = lcr;
    e = expRead(a, lcr, rxCount, txCount);
    @(negedge clk);
    wrEn = 0; rdEn = 0;
    if (doRd) rdM = e;
    if (doWr) applyWrite(a, lcr, d);
    check(req, rdData, rdM);
    checkOutputs(req);
  endtask

  initial begin
    void'($urandom(32'd2291));
    #12;
    check("R1", rdData, 8'h00);
    check("R1", enhMode, 8'h00);
    check("R1", {rxTrigLevel | txTrigLevel}, 8'h00);
    check("R1", {6'b0, irInvert, autoDirEn}, 8'h00);
    @(negedge clk); rstN = 1;

    // R3: scratchpad read/write with swap clear
    busOp(1, 0, 3'd7, 8'h5A, 8'h03, "R3");
    busOp(0, 1, 3'd7, 8'h00, 8'h03, "R3");
    check("R3", rdData, 8'h5A);
    // R2: locked write ignored, unlocked write masks reserved bits
    busOp(1, 0, 3'd1, 8'hFF, 8'h03, "R2");
    busOp(0, 1, 3'd1, 8'h00, 8'hBF, "R2");
    check("R2", rdData, 8'h00);
    busOp(1, 0, 3'd1, 8'hFF, 8'hBF, "R2");
    busOp(0, 1, 3'd1, 8'h00, 8'hBF, "R2");
    check("R2", rdData, 8'hCC);
    // R4: count reads, TX direction then RX, with saturation
    txCount = 5'd20; rxCount = 5'd9;
    busOp(0, 1, 3'd7, 8'h00, 8'h03, "R4");
    check("R4", rdData, 8'd16);
    busOp(1, 0, 3'd1, 8'h40, 8'hBF, "R2");
    busOp(0, 1, 3'd7, 8'h00, 8'h03, "R4");
    check("R4", rdData, 8'd9);
    // R8: hold while rdEn low
    rxCount = 5'd3;
    @(negedge clk); @(negedge clk);
    check("R8", rdData, 8'd9);
    // R5: enhanced write, scratchpad untouched
    busOp(1, 0, 3'd7, 8'hA7, 8'h03, "R5");
    check("R5", enhMode, 8'hA7);
    // R6: trigger writes via swap and via unlock; address 0 reads 0
    busOp(1, 0, 3'd0, 8'd11, 8'h03, "R6");
    check("R6", rxTrigLevel, 8'd11);
    busOp(1, 0, 3'd1, 8'h80, 8'hBF, "R2");
    busOp(1, 0, 3'd0, 8'd22, 8'h03, "R6");
    check("R6", txTrigLevel, 8'd11 ^ 8'd11);
    busOp(1, 0, 3'd0, 8'd6, 8'hBF, "R6");
    check("R6", txTrigLevel, 8'd6);
    busOp(0, 1, 3'd0, 8'h00, 8'hBF, "R6");
    check("R6", rdData, 8'h00);
    busOp(1, 0, 3'd1, 8'h00, 8'hBF, "R2");
    busOp(0, 1, 3'd7, 8'h00, 8'h03, "R5");
    check("R5", rdData, 8'h5A);
    // R8: read and write together, read sees old value
    busOp(1, 1, 3'd7, 8'h33, 8'h03, "R8");
    check("R8", rdData, 8'h5A);
    // R9: unowned addresses
    busOp(0, 1, 3'd4, 8'h00, 8'hBF, "R9");
    check("R9", rdData, 8'h00);
    busOp(0, 1, 3'd1, 8'h00, 8'h00, "R9");
    check("R9", rdData, 8'h00);
    // R7: fixed levels
    for (int s = 0; s < 4; s++) begin
      @(negedge clk); trigTableSel = 2'(s % 3); fixedLevelSel = 2'(s);
      #1 check("R7", rxTrigLevel, fixedLvl(2'(s)));
      check("R7", txTrigLevel, fixedLvl(2'(s)));
    end
    trigTableSel = 2'd3;

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] a;
      logic [7:0] lcr;
      a = ($urandom % 3 == 0) ? 3'($urandom % 8) : (($urandom % 2) ? 3'd7 : 3'($urandom % 2));
      lcr = ($urandom % 2) ? 8'hBF : 8'($urandom);
      rxCount = 5'($urandom % 21);
      txCount = 5'($urandom % 21);
      if (i % 50 == 0) begin
        trigTableSel = 2'($urandom);
        fixedLevelSel = 2'($urandom);
      end
      busOp(1'($urandom), 1'($urandom), a, 8'($urandom), lcr, "R4/R6 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule